// File: doc/BRIEF.md
# Lock-Bit Set Sequencer

This block sits on the host side of a flash-style command bus and carries out one lock-bit set operation per start request. The request names either one block (a block lock bit at the given address) or the whole device (the single master lock bit at a fixed device address). The sequencer makes a two-write setup/confirm pair, then reads the device status every cycle until the write engine reports ready. A programmable limit bounds the number of status reads.

When the request is flagged as the last of a batch, the sequencer decodes the error bits of the status byte into a result code. If there is an error, it issues a clear-status command. In every case it ends by returning the device to read-array mode. When the request is not the last one, decoding is deferred: the device keeps its error bits, so a later final request sees the errors of the whole batch.

The host side is a start/busy/done handshake. A 3-bit result code is valid while done is high. The bus is single-cycle: a write strobe with address and data, or a read strobe whose data is sampled in the same cycle.

States: IDLE (after reset), SETUP (write 60H), CONFIRM (write 01H or F1H), POLL (read status), CLEAR (write 50H), EXIT (write FFH), DONE (result held). Transitions:
- IDLE or DONE goes to SETUP on start.
- SETUP goes to CONFIRM, and CONFIRM goes to POLL.
- POLL goes to DONE when ready and not last.
- POLL goes to CLEAR when ready, last and an error is decoded.
- POLL goes to EXIT when ready, last and no error, or when the read limit expires.
- CLEAR goes to EXIT, and EXIT goes to DONE.

Top module: `lbs_seq`

## Requirements
- R1: After reset, busy_o and done_o are 0 and neither bus strobe is active.
- R2: The first write after an accepted start carries data 60H. Its address is addr_i for a block request (master_i=0) or the DEV_ADDR parameter for a master request (master_i=1).
- R3: The cycle after the setup write is a write of 01H (block) or F1H (master) to the same address.
- R4: After the confirm write, the block asserts bus_re_o each cycle until bus_rdata_i bit 7 is 1. It issues no write while polling.
- R5: On a last request, the result is taken from the final status byte in this priority order. Bit 3 set gives 1 (voltage error). Otherwise bit 1 set gives 2 (protect error). Otherwise bits 5 and 4 both set give 3 (sequence error). Otherwise bit 4 set gives 4 (lock error). Otherwise the result is 0 (success).
- R6: On a last request with a non-zero decoded result, the block writes 50H and then FFH. On success, it writes only FFH. All writes of an operation use the operation's address.
- R7: On a request with last_i=0, the result is 6 (deferred) and no 50H or FFH is written. The device's error bits therefore accumulate into a later last request.
- R8: If bit 7 is still 0 after poll_limit_i reads (a limit of 0 acts as 1), the result is 5 (timeout). FFH is then written without 50H.
- R9: busy_o is high from the accepted start until done_o rises. The two are never high together. done_o and result_o hold until the next start. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled in IDLE or DONE |
| master_i | input | 1 | 1 = master lock bit, 0 = block lock bit |
| last_i | input | 1 | 1 = decode status and restore read-array mode |
| addr_i | input | AW | Block address |
| poll_limit_i | input | TW | Maximum number of status reads |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished, result valid |
| result_o | output | 3 | Result code (0 ok, 1 voltage, 2 protect, 3 sequence, 4 lock, 5 timeout, 6 deferred) |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | 8 | Bus write data |
| bus_we_o | output | 1 | Bus write strobe |
| bus_re_o | output | 1 | Bus read strobe |
| bus_rdata_i | input | 8 | Status byte, valid in the read-strobe cycle |

## Verification
The bench builds the block with AW=16, TW=8 and DEV_ADDR=0F00H, so a master request is told apart from any random block address by its bus address. A poll limit of 20 against device latencies of 0 to 15 cycles covers both short and long ready waits. A latency of 40 drives the read counter into expiry. The narrow 8-bit limit keeps the timeout case to a few dozen cycles, and batches of deferred requests show error bits from several operations meeting in one priority decode.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CONFIRM,
        ST_POLL,
        ST_CLEAR,
        ST_EXIT,
        ST_DONE
    } lbs_state_t;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_VOLT    = 3'd1,
        RES_PROT    = 3'd2,
        RES_SEQ     = 3'd3,
        RES_LOCK    = 3'd4,
        RES_TIMEOUT = 3'd5,
        RES_DEFER   = 3'd6
    } lbs_res_t;

    localparam logic [7:0] CMD_SETUP    = 8'h60;
    localparam logic [7:0] CMD_BLK_CONF = 8'h01;
    localparam logic [7:0] CMD_MST_CONF = 8'hF1;
    localparam logic [7:0] CMD_CLR_STAT = 8'h50;
    localparam logic [7:0] CMD_READ_ARR = 8'hFF;

    localparam int READY_BIT = 7;
    localparam int VOLT_BIT  = 3;
    localparam int PROT_BIT  = 1;
    localparam int SEQ_BIT   = 5;
    localparam int LOCK_BIT  = 4;

endpackage

// File: rtl/lbs_status_decode.sv
module lbs_status_decode
    import lbs_pkg::*;
(
    input  logic     volt_i,
    input  logic     prot_i,
    input  logic     seq_i,
    input  logic     lock_i,
    output lbs_res_t res_o,
    output logic     err_o
);
    always_comb begin
        err_o = 1'b1;
        if (volt_i)               res_o = RES_VOLT;
        else if (prot_i)          res_o = RES_PROT;
        else if (seq_i && lock_i) res_o = RES_SEQ;
        else if (lock_i)          res_o = RES_LOCK;
        else begin
            res_o = RES_OK;
            err_o = 1'b0;
        end
    end
endmodule

// File: rtl/lbs_poll_timer.sv
module lbs_poll_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic [TW-1:0] limit_i,
    output logic          expired_o
);
    localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

    logic [TW-1:0] cnt_q;
    logic [TW:0]   reads_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (clr_i)                     cnt_q <= '0;
        else if (en_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
    end

    // Reads made including the one in this cycle.
    assign reads_now = {1'b0, cnt_q} + 1'b1;
    assign expired_o = en_i && (reads_now >= {1'b0, limit_i});
endmodule

// File: rtl/lbs_seq.sv
module lbs_seq
    import lbs_pkg::*;
#(
    parameter int AW       = 24,
    parameter int TW       = 16,
    parameter int DEV_ADDR = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          master_i,
    input  logic          last_i,
    input  logic [AW-1:0] addr_i,
    input  logic [TW-1:0] poll_limit_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [2:0]    result_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [7:0]    bus_wdata_o,
    output logic          bus_we_o,
    output logic          bus_re_o,
    input  logic [7:0]    bus_rdata_i
);
    localparam logic [AW-1:0] DEV_A = AW'(DEV_ADDR);

    lbs_state_t    st_q, st_nx;
    lbs_res_t      res_q, res_nx;
    lbs_res_t      dec_res;
    logic          dec_err;
    logic          tmo;
    logic          accept;
    logic          ready;
    logic [AW-1:0] tgt_q;
    logic          mst_q, last_q;
    logic          unused_bits;

    assign unused_bits = ^{bus_rdata_i[6], bus_rdata_i[2], bus_rdata_i[0]};
    assign ready  = bus_rdata_i[READY_BIT];
    assign accept = start_i && (st_q == ST_IDLE || st_q == ST_DONE);

    lbs_status_decode u_dec (
        .volt_i (bus_rdata_i[VOLT_BIT]),
        .prot_i (bus_rdata_i[PROT_BIT]),
        .seq_i  (bus_rdata_i[SEQ_BIT]),
        .lock_i (bus_rdata_i[LOCK_BIT]),
        .res_o  (dec_res),
        .err_o  (dec_err)
    );

    lbs_poll_timer #(.TW(TW)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (st_q != ST_POLL),
        .en_i      (st_q == ST_POLL),
        .limit_i   (poll_limit_i),
        .expired_o (tmo)
    );

    // State register and captured request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            res_q  <= RES_OK;
            tgt_q  <= '0;
            mst_q  <= 1'b0;
            last_q <= 1'b0;
        end else begin
            st_q  <= st_nx;
            res_q <= res_nx;
            if (accept) begin
                tgt_q  <= master_i ? DEV_A : addr_i;
                mst_q  <= master_i;
                last_q <= last_i;
            end
        end
    end

    // Transitions.
    always_comb begin
        st_nx  = st_q;
        res_nx = res_q;
        unique case (st_q)
            ST_IDLE, ST_DONE: if (start_i) st_nx = ST_SETUP;
            ST_SETUP:         st_nx = ST_CONFIRM;
            ST_CONFIRM:       st_nx = ST_POLL;
            ST_POLL: begin
                if (ready) begin
                    if (!last_q) begin
                        st_nx  = ST_DONE;
                        res_nx = RES_DEFER;
                    end else if (dec_err) begin
                        st_nx  = ST_CLEAR;
                        res_nx = dec_res;
                    end else begin
                        st_nx  = ST_EXIT;
                        res_nx = RES_OK;
                    end
                end else if (tmo) begin
                    st_nx  = ST_EXIT;
                    res_nx = RES_TIMEOUT;
                end
            end
            ST_CLEAR:         st_nx = ST_EXIT;
            ST_EXIT:          st_nx = ST_DONE;
            default:          st_nx = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        busy_o      = 1'b0;
        done_o      = 1'b0;
        bus_we_o    = 1'b0;
        bus_re_o    = 1'b0;
        bus_wdata_o = 8'h00;
        unique case (st_q)
            ST_IDLE: ;
            ST_DONE: done_o = 1'b1;
            ST_SETUP: begin
                busy_o = 1'b1; bus_we_o = 1'b1; bus_wdata_o = CMD_SETUP;
            end
            ST_CONFIRM: begin
                busy_o = 1'b1; bus_we_o = 1'b1;
                bus_wdata_o = mst_q ? CMD_MST_CONF : CMD_BLK_CONF;
            end
            ST_POLL: begin
                busy_o = 1'b1; bus_re_o = 1'b1;
            end
            ST_CLEAR: begin
                busy_o = 1'b1; bus_we_o = 1'b1; bus_wdata_o = CMD_CLR_STAT;
            end
            ST_EXIT: begin
                busy_o = 1'b1; bus_we_o = 1'b1; bus_wdata_o = CMD_READ_ARR;
            end
            default: ;
        endcase
    end

    assign bus_addr_o = tgt_q;
    assign result_o   = res_q;
endmodule

// File: rtl/lbs_seq_chk.sv
module lbs_seq_chk #(
    parameter int AW = 24,
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [TW-1:0] poll_limit_i,
    input logic          busy_o,
    input logic          done_o,
    input logic [2:0]    result_o,
    input logic [AW-1:0] bus_addr_o,
    input logic [7:0]    bus_wdata_o,
    input logic          bus_we_o,
    input logic          bus_re_o
);
    logic [TW-1:0] rd_run_q;
    logic [TW-1:0] lim_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             rd_run_q <= '0;
        else if (!bus_re_o)     rd_run_q <= '0;
        else if (rd_run_q != {TW{1'b1}}) rd_run_q <= rd_run_q + 1'b1;
    end

    assign lim_eff = (poll_limit_i == '0) ? TW'(1) : poll_limit_i;

    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_o, done_o}));

    // R4
    bus_dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we_o && bus_re_o));

    // R3
    confirm_follows_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_o && bus_wdata_o == 8'h60) |=>
        (bus_we_o && (bus_wdata_o == 8'h01 || bus_wdata_o == 8'hF1) && $stable(bus_addr_o)));

    // R6
    exit_follows_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_o && bus_wdata_o == 8'h50) |=> (bus_we_o && bus_wdata_o == 8'hFF));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(result_o)));

    // R8
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re_o |-> (rd_run_q < lim_eff));
endmodule

bind lbs_seq lbs_seq_chk #(.AW(AW), .TW(TW)) i_lbs_seq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .poll_limit_i (poll_limit_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .result_o     (result_o),
    .bus_addr_o   (bus_addr_o),
    .bus_wdata_o  (bus_wdata_o),
    .bus_we_o     (bus_we_o),
    .bus_re_o     (bus_re_o)
);

// File: tb/test_lbs_seq.sv
module test_lbs_seq;
    localparam int AW  = 16;
    localparam int TW  = 8;
    localparam int DEV = 'h0F00;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, master_i = 1'b0, last_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [TW-1:0] poll_limit_i = 8'd20;
    logic          busy_o, done_o, bus_we_o, bus_re_o;
    logic [2:0]    result_o;
    logic [AW-1:0] bus_addr_o;
    logic [7:0]    bus_wdata_o, bus_rdata_i;

    int checks = 0, errors = 0;

    // Device model state.
    logic       dv_ready = 1'b1, dv_armed = 1'b0;
    logic [7:0] dv_acc = 8'h00, dv_inj = 8'h00;
    int         dv_cnt = 0, dv_lat = 0;
    // Write log.
    logic [AW-1:0] log_a [8];
    logic [7:0]    log_d [8];
    int            log_n = 0;
    logic [7:0]    exp_acc = 8'h00;

    always #5 clk = ~clk;

    lbs_seq #(.AW(AW), .TW(TW), .DEV_ADDR(DEV)) i_lbs_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .master_i(master_i),
        .last_i(last_i), .addr_i(addr_i), .poll_limit_i(poll_limit_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
        .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
        .bus_we_o(bus_we_o), .bus_re_o(bus_re_o), .bus_rdata_i(bus_rdata_i));

    assign bus_rdata_i = {dv_ready, 7'b0} | (dv_acc & 8'h3A);

    always @(negedge clk) begin
        if (!dv_ready) begin
            if (dv_cnt == 0) begin
                dv_ready = 1'b1;
                dv_acc   = dv_acc | dv_inj;
            end else dv_cnt = dv_cnt - 1;
        end
        if (bus_we_o) begin
            if (log_n < 8) begin
                log_a[log_n] = bus_addr_o;
                log_d[log_n] = bus_wdata_o;
            end
            log_n = log_n + 1;
            if (dv_ready) begin
                case (bus_wdata_o)
                    8'h60: dv_armed = 1'b1;
                    8'h01, 8'hF1: if (dv_armed) begin
                        dv_ready = 1'b0; dv_cnt = dv_lat; dv_armed = 1'b0;
                    end
                    8'h50: begin dv_acc = 8'h00; dv_armed = 1'b0; end
                    default: dv_armed = 1'b0;
                endcase
            end
        end
    end

    function automatic logic [2:0] exp_decode(input logic [7:0] s);
        if (s[3]) return 3'd1;
        if (s[1]) return 3'd2;
        if (s[5] && s[4]) return 3'd3;
        if (s[4]) return 3'd4;
        return 3'd0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_op(input bit m, input logic [AW-1:0] a, input bit l,
                          input logic [7:0] inj, input int lat,
                          input bit tmo, input bit poke);
        logic [AW-1:0] ea;
        logic [7:0]    ed [5];
        int            en, wd;
        logic [2:0]    er, held;
        ea = m ? AW'(DEV) : a;
        dv_inj = inj; dv_lat = lat;
        @(negedge clk);
        log_n = 0;
        start_i = 1'b1; master_i = m; addr_i = a; last_i = l;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && !done_o, "R9 busy after start", busy_o, 1);
        if (poke) begin
            @(negedge clk);
            start_i = 1'b1; master_i = !m; addr_i = ~a;
            @(negedge clk);
            start_i = 1'b0;
        end
        wd = 0;
        while (!done_o && wd < 2000) begin @(negedge clk); wd++; end
        chk(wd < 2000, "R9 done reached", wd, 0);
        ed[0] = 8'h60; ed[1] = m ? 8'hF1 : 8'h01; en = 2;
        if (tmo) begin
            er = 3'd5; ed[en] = 8'hFF; en++;
        end else begin
            exp_acc = exp_acc | inj;
            if (!l) er = 3'd6;
            else begin
                er = exp_decode(exp_acc);
                if (er != 3'd0) begin ed[en] = 8'h50; en++; exp_acc = 8'h00; end
                ed[en] = 8'hFF; en++;
            end
        end
        chk(result_o == er, tmo ? "R8 result" : (l ? "R5 result" : "R7 result"), result_o, er);
        chk(log_n == en, l ? "R6 write count" : "R7 write count", log_n, en);
        for (int i = 0; i < 5; i++) begin
            if (i < en && i < log_n) begin
                chk(log_d[i] == ed[i], i == 0 ? "R2 data" : (i == 1 ? "R3 data" : "R6 data"),
                    log_d[i], ed[i]);
                chk(log_a[i] == ea, "R2 address", log_a[i], ea);
            end
        end
        held = result_o;
        repeat (3) @(negedge clk);
        chk(done_o && result_o == held, "R9 hold", result_o, held);
        if (tmo) begin
            while (!dv_ready) @(negedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(1234);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !bus_we_o && !bus_re_o, "R1 reset", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !bus_we_o && !bus_re_o, "R1 idle", done_o, 0);
        // R5/R6 directed priority cases
        run_op(0, 16'h1234, 1, 8'h00, 3, 0, 0);
        run_op(1, 16'h0000, 1, 8'h0A, 0, 0, 0);   // bit3 beats bit1
        run_op(0, 16'h4000, 1, 8'h32, 5, 0, 0);   // bit1 beats 5+4
        run_op(0, 16'h4001, 1, 8'h30, 2, 0, 0);
        run_op(1, 16'h4002, 1, 8'h10, 7, 0, 0);
        run_op(0, 16'h4003, 1, 8'h20, 1, 0, 0);   // bit5 alone is success
        // R7 deferred batch: 10H then 20H, decoded as sequence error
        run_op(0, 16'h0100, 0, 8'h10, 4, 0, 0);
        run_op(0, 16'h0200, 0, 8'h20, 4, 0, 0);
        run_op(1, 16'h0300, 1, 8'h00, 4, 0, 0);
        // R8 timeout, then limit 0
        run_op(0, 16'h0500, 1, 8'h00, 40, 1, 0);
        poll_limit_i = 8'd0;
        run_op(0, 16'h0600, 1, 8'h00, 3, 1, 0);
        poll_limit_i = 8'd20;
        // R9 start ignored while busy
        run_op(0, 16'h0700, 1, 8'h00, 10, 0, 1);
        // Random mix for R2..R7
        for (int k = 0; k < 40; k++) begin
            logic [7:0] inj_r;
            inj_r = 8'($urandom) & 8'h3A;
            if ($urandom_range(0, 2) == 0) inj_r = 8'h00;
            run_op(1'($urandom), 16'($urandom), 1'($urandom_range(0, 2) != 0),
                   inj_r, $urandom_range(0, 15), 0, k % 7 == 3);
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule